// File: doc/BRIEF.md
# Latched Interrupt and Non-Maskable Interrupt Controller

This block gathers request lines from peripherals into two latch-and-enable register pairs. One pair drives the maskable interrupt line `irq`, and the other drives the non-maskable line `nmi`. Each level source updates its latch bit only when its level changes: a rising edge sets the bit and a falling edge clears it. The cassette edge strobes work differently. They copy the matching enable bit into the latch. The CPU reaches the four registers through a single-cycle port selected by `reg_sel`. Reads return data combinationally in the same cycle. Writes and events take effect on the next clock edge.

The static input `legacy_mode` picks one of two behaviours and may change only under reset. In extended mode (`legacy_mode`=0), `irq` is always the OR of latch AND enable. In legacy mode, `irq` is controlled by a three-state view machine:
- `ST_MASKED`: `irq` is the OR of latch AND enable.
- `ST_FORCED`: `irq` is held at 1.
- `ST_RAW`: `irq` is the OR of all latch bits.

The view machine changes state on three named transitions, listed in priority order:
- T_EVENT: a legacy timer or disk rising edge moves it to `ST_FORCED`.
- T_ACK: a legacy latch read moves it to `ST_RAW`. The same read clears only the timer bit.
- T_MASKWR: a write of the maskable enable register moves it to `ST_MASKED`.

Outside legacy mode the machine stays in `ST_MASKED`.

Top module: `latched_int_ctrl`

## Requirements
- R1: After reset the maskable latch and enable are 0x00, the NMI latch is `NMI_LATCH_INIT` (default 0x01), the NMI enable is 0x20, and `irq` and `nmi` are 0.
- R2: The register port encodes `reg_sel` as follows: 0 reads the maskable latch, 1 writes the maskable enable, 2 reads the NMI latch, 3 writes the NMI enable. `rd_data` is valid in the same cycle as `rd_en`, and a write takes effect at the next clock edge.
- R3: In extended mode, `irq` equals the OR of (maskable latch AND enable). It reflects an event or an enable write in the cycle after that event or write.
- R4: In extended mode, the level sources map to maskable latch bits as follows: UART error bit 6, UART receive bit 5, UART transmit bit 4, timer bit 2. Each bit is set on its source's rising edge and cleared on its falling edge. Bit 7 is never set.
- R5: In extended mode, a `cas_rise` strobe loads latch bit 0 from enable bit 0, and a `cas_fall` strobe loads latch bit 1 from enable bit 1. `cas_clr` clears both of these bits and takes priority over the strobes.
- R6: An extended-mode read of the maskable latch returns its bitwise complement. A read of the NMI latch returns its complement in either mode.
- R7: In extended mode, the NMI latch bits are: disk INTRQ bit 7, motor timeout bit 6, reset button bit 5. `nmi` equals the OR of (NMI latch AND NMI enable).
- R8: Every write to the NMI enable stores the written value ORed with 0x20, so the reset-button NMI can never be disabled.
- R9: In legacy mode, the timer maps to maskable latch bit 7 and the disk to bit 6. A rising edge of either forces `irq` to 1 whatever the enable holds.
- R10: In legacy mode, a maskable latch read returns the true stored value and then clears only bit 7. From then on `irq` is the OR of all latch bits, until the next enable write or legacy event.
- R11: In legacy mode, `nmi` follows the reset-button latch bit directly, independent of the NMI enable. The motor, UART and cassette inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1 selects legacy behaviour; static between resets |
| timer_src | input | 1 | Timer request level |
| uart_err_src | input | 1 | UART error request level |
| uart_rx_src | input | 1 | UART receive request level |
| uart_tx_src | input | 1 | UART transmit request level |
| disk_src | input | 1 | Disk controller INTRQ level |
| motor_src | input | 1 | Drive motor timeout level |
| reset_btn | input | 1 | Reset button level |
| cas_rise | input | 1 | Cassette rising-edge event strobe |
| cas_fall | input | 1 | Cassette falling-edge event strobe |
| cas_clr | input | 1 | Clears both cassette latch bits |
| reg_sel | input | 2 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Maskable interrupt request |
| nmi | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its default `NMI_LATCH_INIT` of 0x01. This makes the non-zero NMI reset value visible through the complemented read path. The bench runs one reset in each mode. This covers both the mask-bypassing view machine in legacy mode and the cassette copy-from-enable behaviour in extended mode. It also checks the acknowledge sequence in which the timer bit drops while the disk bit keeps `irq` high.

// File: rtl/lic_pkg.sv
package lic_pkg;
    localparam int DW = 8;

    // level source indices into the edge detector vector
    localparam int SRC_TIMER = 0;
    localparam int SRC_UERR  = 1;
    localparam int SRC_URX   = 2;
    localparam int SRC_UTX   = 3;
    localparam int SRC_DISK  = 4;
    localparam int SRC_MOTOR = 5;
    localparam int SRC_RESET = 6;
    localparam int NUM_SRC   = 7;

    // maskable latch positions, extended mode
    localparam int XB_UERR  = 6;
    localparam int XB_URX   = 5;
    localparam int XB_UTX   = 4;
    localparam int XB_TIMER = 2;
    localparam int XB_CFALL = 1;
    localparam int XB_CRISE = 0;
    // maskable latch positions, legacy mode
    localparam int LB_TIMER = 7;
    localparam int LB_DISK  = 6;
    // NMI latch positions
    localparam int NB_DISK  = 7;
    localparam int NB_MOTOR = 6;
    localparam int NB_RESET = 5;

    localparam logic [DW-1:0] NMI_KEEP = 8'h20;

    // register select codes
    localparam logic [1:0] SEL_IRQ_LATCH = 2'd0;
    localparam logic [1:0] SEL_IRQ_MASK  = 2'd1;
    localparam logic [1:0] SEL_NMI_LATCH = 2'd2;
    localparam logic [1:0] SEL_NMI_MASK  = 2'd3;

    typedef enum logic [1:0] {
        ST_MASKED = 2'd0,
        ST_FORCED = 2'd1,
        ST_RAW    = 2'd2
    } irq_view_e;
endpackage

// File: rtl/lic_edge.sv
module lic_edge #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end
endmodule

// File: rtl/lic_irq_fsm.sv
module lic_irq_fsm
    import lic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      legacy,
    input  logic      leg_event,
    input  logic      ack,
    input  logic      mask_we,
    output irq_view_e state
);
    irq_view_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_MASKED;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!legacy)        state_d = ST_MASKED;
        else if (leg_event) state_d = ST_FORCED;  // T_EVENT
        else if (ack)       state_d = ST_RAW;     // T_ACK
        else if (mask_we)   state_d = ST_MASKED;  // T_MASKWR
    end

    assign state = state_q;

    assert_forced_R9: assert property (@(posedge clk) disable iff (rst)
        (legacy && leg_event) |=> (state_q == ST_FORCED));
    assert_ext_view_R3: assert property (@(posedge clk) disable iff (rst)
        (!legacy && !$past(legacy)) |-> (state_q == ST_MASKED));
endmodule

// File: rtl/lic_irq_bank.sv
module lic_irq_bank
    import lic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               legacy,
    input  logic [NUM_SRC-1:0] rise,
    input  logic [NUM_SRC-1:0] fall,
    input  logic               cas_rise,
    input  logic               cas_fall,
    input  logic               cas_clr,
    input  logic               ack,
    input  logic               mask_we,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      latch,
    output logic [DW-1:0]      mask
);
    logic [DW-1:0] latch_q, latch_d, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            mask_q  <= '0;
        end else begin
            latch_q <= latch_d;
            if (mask_we) mask_q <= wdata;
        end
    end

    always_comb begin
        latch_d = latch_q;
        if (legacy) begin
            if (rise[SRC_TIMER])      latch_d[LB_TIMER] = 1'b1;
            else if (fall[SRC_TIMER]) latch_d[LB_TIMER] = 1'b0;
            else if (ack)             latch_d[LB_TIMER] = 1'b0;
            if (rise[SRC_DISK])       latch_d[LB_DISK]  = 1'b1;
            else if (fall[SRC_DISK])  latch_d[LB_DISK]  = 1'b0;
        end else begin
            if (rise[SRC_UERR])       latch_d[XB_UERR]  = 1'b1;
            else if (fall[SRC_UERR])  latch_d[XB_UERR]  = 1'b0;
            if (rise[SRC_URX])        latch_d[XB_URX]   = 1'b1;
            else if (fall[SRC_URX])   latch_d[XB_URX]   = 1'b0;
            if (rise[SRC_UTX])        latch_d[XB_UTX]   = 1'b1;
            else if (fall[SRC_UTX])   latch_d[XB_UTX]   = 1'b0;
            if (rise[SRC_TIMER])      latch_d[XB_TIMER] = 1'b1;
            else if (fall[SRC_TIMER]) latch_d[XB_TIMER] = 1'b0;
            if (cas_clr) begin
                latch_d[XB_CRISE] = 1'b0;
                latch_d[XB_CFALL] = 1'b0;
            end else begin
                if (cas_rise) latch_d[XB_CRISE] = mask_q[XB_CRISE];
                if (cas_fall) latch_d[XB_CFALL] = mask_q[XB_CFALL];
            end
        end
    end

    assign latch = latch_q;
    assign mask  = mask_q;

    assert_bus_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!legacy && !$past(legacy) && !$past(latch_q[7])) |-> !latch_q[7]);
    assert_cas_load_R5: assert property (@(posedge clk) disable iff (rst)
        (!legacy && cas_rise && !cas_clr) |=> (latch_q[XB_CRISE] == $past(mask_q[XB_CRISE])));
    assert_cas_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (!legacy && cas_clr) |=> (latch_q[XB_CRISE] == 1'b0 && latch_q[XB_CFALL] == 1'b0));
    assert_ack_timer_R10: assert property (@(posedge clk) disable iff (rst)
        (legacy && ack && !rise[SRC_TIMER]) |=> !latch_q[LB_TIMER]);
endmodule

// File: rtl/lic_nmi_bank.sv
module lic_nmi_bank
    import lic_pkg::*;
#(
    parameter logic [DW-1:0] LATCH_INIT = 8'h01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               legacy,
    input  logic [NUM_SRC-1:0] rise,
    input  logic [NUM_SRC-1:0] fall,
    input  logic               mask_we,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      latch,
    output logic               nmi
);
    logic [DW-1:0] latch_q, latch_d, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= LATCH_INIT;
            mask_q  <= NMI_KEEP;
        end else begin
            latch_q <= latch_d;
            if (mask_we) mask_q <= wdata | NMI_KEEP;
        end
    end

    always_comb begin
        latch_d = latch_q;
        if (rise[SRC_RESET])      latch_d[NB_RESET] = 1'b1;
        else if (fall[SRC_RESET]) latch_d[NB_RESET] = 1'b0;
        if (!legacy) begin
            if (rise[SRC_DISK])       latch_d[NB_DISK]  = 1'b1;
            else if (fall[SRC_DISK])  latch_d[NB_DISK]  = 1'b0;
            if (rise[SRC_MOTOR])      latch_d[NB_MOTOR] = 1'b1;
            else if (fall[SRC_MOTOR]) latch_d[NB_MOTOR] = 1'b0;
        end
    end

    assign latch = latch_q;
    assign nmi   = legacy ? latch_q[NB_RESET] : |(latch_q & mask_q);

    assert_keep_reset_R8: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> mask_q[NB_RESET]);
    assert_btn_nmi_R8: assert property (@(posedge clk) disable iff (rst)
        rise[SRC_RESET] |=> nmi);
    assert_leg_motor_R11: assert property (@(posedge clk) disable iff (rst)
        (legacy && rise[SRC_MOTOR]) |=> !latch_q[NB_MOTOR] || $past(latch_q[NB_MOTOR]));
endmodule

// File: rtl/latched_int_ctrl.sv
module latched_int_ctrl
    import lic_pkg::*;
#(
    parameter logic [7:0] NMI_LATCH_INIT = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       legacy_mode,
    input  logic       timer_src,
    input  logic       uart_err_src,
    input  logic       uart_rx_src,
    input  logic       uart_tx_src,
    input  logic       disk_src,
    input  logic       motor_src,
    input  logic       reset_btn,
    input  logic       cas_rise,
    input  logic       cas_fall,
    input  logic       cas_clr,
    input  logic [1:0] reg_sel,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       nmi
);
    logic [NUM_SRC-1:0] lvl, rise, fall;
    logic [DW-1:0]      il, im, nl;
    logic               ack, imask_we, nmask_we, leg_event;
    irq_view_e          view;

    always_comb begin
        lvl            = '0;
        lvl[SRC_TIMER] = timer_src;
        lvl[SRC_UERR]  = uart_err_src;
        lvl[SRC_URX]   = uart_rx_src;
        lvl[SRC_UTX]   = uart_tx_src;
        lvl[SRC_DISK]  = disk_src;
        lvl[SRC_MOTOR] = motor_src;
        lvl[SRC_RESET] = reset_btn;
    end

    assign ack       = legacy_mode && rd_en && (reg_sel == SEL_IRQ_LATCH);
    assign imask_we  = wr_en && (reg_sel == SEL_IRQ_MASK);
    assign nmask_we  = wr_en && (reg_sel == SEL_NMI_MASK);
    assign leg_event = legacy_mode && (rise[SRC_TIMER] || rise[SRC_DISK]);

    lic_edge #(.N(NUM_SRC)) u_edge (
        .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall)
    );

    lic_irq_bank u_irq (
        .clk(clk), .rst(rst), .legacy(legacy_mode), .rise(rise), .fall(fall),
        .cas_rise(cas_rise), .cas_fall(cas_fall), .cas_clr(cas_clr),
        .ack(ack), .mask_we(imask_we), .wdata(wr_data), .latch(il), .mask(im)
    );

    lic_nmi_bank #(.LATCH_INIT(NMI_LATCH_INIT)) u_nmi (
        .clk(clk), .rst(rst), .legacy(legacy_mode), .rise(rise), .fall(fall),
        .mask_we(nmask_we), .wdata(wr_data), .latch(nl), .nmi(nmi)
    );

    lic_irq_fsm u_fsm (
        .clk(clk), .rst(rst), .legacy(legacy_mode), .leg_event(leg_event),
        .ack(ack), .mask_we(imask_we), .state(view)
    );

    always_comb begin
        irq = 1'b0;
        unique case (view)
            ST_MASKED: irq = |(il & im);
            ST_FORCED: irq = 1'b1;
            ST_RAW:    irq = |il;
            default:   irq = 1'b0;
        endcase
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (reg_sel)
                SEL_IRQ_LATCH: rd_data = legacy_mode ? il : ~il;
                SEL_NMI_LATCH: rd_data = ~nl;
                default:       rd_data = '0;
            endcase
        end
    end

    assert_leg_raise_R9: assert property (@(posedge clk) disable iff (rst)
        leg_event |=> irq);
    assert_ext_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (!legacy_mode && imask_we && wr_data == 8'h00) |=> !irq);
endmodule

// File: tb/sim_latched_int_ctrl.sv
module sim_latched_int_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       legacy_mode = 1'b0;
    logic       timer_src = 0, uart_err_src = 0, uart_rx_src = 0, uart_tx_src = 0;
    logic       disk_src = 0, motor_src = 0, reset_btn = 0;
    logic       cas_rise = 0, cas_fall = 0, cas_clr = 0;
    logic [1:0] reg_sel = 0;
    logic       rd_en = 0, wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       irq, nmi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    latched_int_ctrl u0 (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(bit leg);
        rst = 1'b1;
        legacy_mode = leg;
        {timer_src, uart_err_src, uart_rx_src, uart_tx_src, disk_src, motor_src, reset_btn} = '0;
        {cas_rise, cas_fall, cas_clr, rd_en, wr_en} = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [7:0] d);
        reg_sel = sel; rd_en = 1'b1;
        #1 d = rd_data;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic t_reset_ext();
        logic [7:0] d;
        do_reset(1'b0);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 nmi", {7'd0, nmi}, 8'h00);
        rd(2'd0, d); chk("R1/R6 irq latch read", d, 8'hFF);
        rd(2'd2, d); chk("R1/R6 nmi latch read", d, 8'hFE);
    endtask

    task automatic t_uart_timer();
        logic [7:0] d;
        wr(2'd1, 8'h20);
        uart_rx_src = 1; tick();
        chk("R3 irq on rx", {7'd0, irq}, 8'h01);
        rd(2'd0, d); chk("R4/R2 rx bit5", d, 8'hDF);
        uart_err_src = 1; uart_tx_src = 1; tick();
        rd(2'd0, d); chk("R4 err bit6 tx bit4", d, 8'h8F);
        wr(2'd1, 8'h00);
        chk("R3 mask write drops irq", {7'd0, irq}, 8'h00);
        uart_rx_src = 0; uart_err_src = 0; uart_tx_src = 0; tick();
        rd(2'd0, d); chk("R4 falling clears", d, 8'hFF);
        timer_src = 1; tick();
        rd(2'd0, d); chk("R4 timer bit2", d, 8'hFB);
        wr(2'd1, 8'h04);
        chk("R3 timer enabled", {7'd0, irq}, 8'h01);
        timer_src = 0; tick();
        chk("R3 timer release", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_cassette();
        logic [7:0] d;
        wr(2'd1, 8'h01);
        cas_rise = 1; tick(); cas_rise = 0;
        chk("R5 rise loads 1", {7'd0, irq}, 8'h01);
        rd(2'd0, d); chk("R5 bit0 set", d, 8'hFE);
        wr(2'd1, 8'h02);
        chk("R3 bit0 unmasked off", {7'd0, irq}, 8'h00);
        cas_rise = 1; tick(); cas_rise = 0;
        rd(2'd0, d); chk("R5 rise loads 0", d, 8'hFF);
        cas_fall = 1; tick(); cas_fall = 0;
        chk("R5 fall loads 1", {7'd0, irq}, 8'h01);
        cas_clr = 1; tick(); cas_clr = 0;
        rd(2'd0, d); chk("R5 clear", d, 8'hFF);
        chk("R5 irq after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_nmi_ext();
        logic [7:0] d;
        wr(2'd3, 8'h00);
        disk_src = 1; tick();
        chk("R7 disk masked", {7'd0, nmi}, 8'h00);
        rd(2'd2, d); chk("R7 disk bit7", d, 8'h7E);
        reset_btn = 1; tick();
        chk("R8 reset kept enabled", {7'd0, nmi}, 8'h01);
        reset_btn = 0; tick();
        chk("R7 reset released", {7'd0, nmi}, 8'h00);
        wr(2'd3, 8'h80);
        chk("R7 disk enabled", {7'd0, nmi}, 8'h01);
        disk_src = 0; tick();
        chk("R7 disk released", {7'd0, nmi}, 8'h00);
        motor_src = 1; tick();
        rd(2'd2, d); chk("R7 motor bit6", d, 8'hBE);
        wr(2'd3, 8'h40);
        chk("R7 motor enabled", {7'd0, nmi}, 8'h01);
        motor_src = 0; tick();
    endtask

    task automatic t_legacy();
        logic [7:0] d;
        do_reset(1'b1);
        chk("R1 legacy irq", {7'd0, irq}, 8'h00);
        timer_src = 1; tick();
        chk("R9 timer forces irq", {7'd0, irq}, 8'h01);
        rd(2'd0, d); chk("R10 true read", d, 8'h80);
        chk("R10 ack clears timer", {7'd0, irq}, 8'h00);
        disk_src = 1; tick();
        chk("R9 disk forces irq", {7'd0, irq}, 8'h01);
        rd(2'd0, d); chk("R10 disk read", d, 8'h40);
        chk("R10 raw view keeps disk", {7'd0, irq}, 8'h01);
        rd(2'd0, d); chk("R10 only timer acked", d, 8'h40);
        wr(2'd1, 8'h00);
        chk("R10 mask write restores masking", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h40);
        chk("R9 disk enabled", {7'd0, irq}, 8'h01);
        disk_src = 0; timer_src = 0; tick();
        chk("R9 disk release", {7'd0, irq}, 8'h00);
        uart_rx_src = 1; cas_fall = 1; tick(); cas_fall = 0;
        rd(2'd0, d); chk("R11 uart/cassette ignored", d, 8'h00);
        reset_btn = 1; tick();
        chk("R11 reset drives nmi", {7'd0, nmi}, 8'h01);
        motor_src = 1; tick();
        rd(2'd2, d); chk("R11 motor ignored", d, 8'hDE);
        reset_btn = 0; tick();
        chk("R11 nmi follows button", {7'd0, nmi}, 8'h00);
    endtask

    initial begin
        t_reset_ext();
        t_uart_timer();
        t_cassette();
        t_nmi_ext();
        t_legacy();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule